// File: doc/BRIEF.md
# Self-Checking Serial Elastic Buffer

This block is a single-bit elastic store that sits between a gated write clock and a free-running read clock. The write side puts each incoming bit into a 16-location ring and steps its address counter only on cycles when the write gate is open. The read side steps its own address counter on every read clock and presents the stored bit one read clock later. After reset the write counter starts eight locations ahead of the read counter. With equal rates the read side therefore sits halfway round the ring from the writer. The top bit of each counter is brought out so that a neighbouring rate-control loop can compare their phases.

An integrity checker runs alongside the data path and checks one location at a time. When no check is outstanding, it captures the address and the bit of the next accepted write. The capture request crosses into the read domain through a synchronizer. Once armed, the read side waits until its counter reaches the captured address. It registers that equality, and on the following read clock it compares the bit that came out of the ring with the captured bit. A difference drives the active-low card error output low. The output stays at that level until a later comparison matches. Only after the comparison has finished does the write side accept a new sample.

Top module: `elastic_buf_chk`

## Requirements
- R1: While reset is asserted and right after it, the write counter MSB reads 1 (counter value 8), the read counter MSB reads 0 (value 0), and card_err_n reads 1.
- R2: A write-clock edge with wr_en high stores wr_data at the write address and advances the write counter by one, modulo 16. A write-clock edge with wr_en low changes neither the counter nor the ring.
- R3: Every read-clock edge advances the read counter by one, modulo 16, and loads rd_data with the bit stored at the read address before that edge.
- R4: Writing on every write clock from reset at the read clock's rate keeps the read counter exactly eight behind the write counter. After each read edge, rd_msb is therefore the inverse of wr_msb.
- R5: The checker captures the address and bit of an accepted write only when no check is outstanding. Both captured values stay unchanged until the outstanding comparison has completed.
- R6: When the checker is armed and the read counter equals the captured address, the comparison takes place on the next read-clock edge. That comparison uses the bit the ring delivered for that address.
- R7: A comparison whose ring bit differs from the captured bit drives card_err_n to 0 (active low). This happens, for example, when the location is overwritten before the reader reaches it.
- R8: card_err_n changes only at a comparison. A matching comparison returns it to 1, and it holds its level between comparisons.
- R9: Continuous streaming with the reset offset intact, or an idle writer, never produces a false error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write gate; a bit is accepted on each write-clock edge while high |
| wr_data | input | 1 | Serial data bit to store |
| rd_clk | input | 1 | Read clock, steps the reader every edge |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rd_data | output | 1 | Bit read from the ring, registered on rd_clk |
| card_err_n | output | 1 | Active-low integrity error, held between comparisons |
| wr_msb | output | 1 | Most significant bit of the write counter |
| rd_msb | output | 1 | Most significant bit of the read counter |

## Verification
A corrupted ring location or a wrong read counter shows on rd_data on the very next read clock. The bench compares each read against its own model of the ring. A checker that reloads its sample while a check is outstanding hides the overwrite fault. In that case card_err_n stays high when it should have fallen within about twenty read clocks. An error flag that does not hold, or that clears without a matching comparison, is caught within a few read clocks after the fault is detected. A pointer that drifts breaks the fixed MSB relation at the first read edge after the drift.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  // Modulo step of a ring counter
  function automatic int unsigned ring_step(int unsigned p, int unsigned depth);
    return (p + 1) % depth;
  endfunction

  // Start position of the writer relative to the reader
  function automatic int unsigned start_lead(int unsigned depth);
    return depth / 2;
  endfunction

  // Comparison of the delivered bit against the captured one
  function automatic logic bits_differ(logic delivered, logic captured);
    return delivered ^ captured;
  endfunction

endpackage

// File: rtl/ebc_sync.sv
module ebc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ebc_wr_side.sv
module ebc_wr_side
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_data,
  input  logic              ack_sync,
  output logic [DEPTH-1:0]  ring_q,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] samp_addr,
  output logic              samp_bit,
  output logic              req_tgl,
  output logic              pending
);
  localparam logic [ADDR_W-1:0] LEAD = ADDR_W'(start_lead(DEPTH));

  logic take;

  assign pending = req_tgl ^ ack_sync;
  assign take    = wr_en & ~pending;

  // Ring storage and write counter
  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= '0;
      wr_ptr <= LEAD;
    end else if (wr_en) begin
      ring_q[wr_ptr] <= wr_data;
      wr_ptr         <= ADDR_W'(ring_step(32'(wr_ptr), DEPTH));
    end
  end

  // Sample latches: loaded only when no check is outstanding
  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_addr <= '0;
      samp_bit  <= 1'b0;
      req_tgl   <= 1'b0;
    end else if (take) begin
      samp_addr <= wr_ptr;
      samp_bit  <= wr_data;
      req_tgl   <= ~req_tgl;
    end
  end
endmodule

// File: rtl/ebc_rd_side.sv
module ebc_rd_side
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [DEPTH-1:0]  ring_q,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              rd_q
);
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      rd_q   <= 1'b0;
    end else begin
      rd_q   <= ring_q[rd_ptr];
      rd_ptr <= ADDR_W'(ring_step(32'(rd_ptr), DEPTH));
    end
  end
endmodule

// File: rtl/ebc_rd_check.sv
module ebc_rd_check
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              req_sync,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic              rd_q,
  input  logic [ADDR_W-1:0] samp_addr,
  input  logic              samp_bit,
  output logic              ack_tgl,
  output logic              hit,
  output logic              cmp_fire,
  output logic              err_q
);
  logic eq_q;
  logic armed;

  assign armed    = (req_sync ^ ack_tgl) & ~eq_q;
  assign hit      = armed & (rd_ptr == samp_addr);
  assign cmp_fire = eq_q;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q    <= 1'b0;
      ack_tgl <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      eq_q <= hit;
      if (eq_q) begin
        err_q   <= bits_differ(rd_q, samp_bit);
        ack_tgl <= ~ack_tgl;
      end
    end
  end
endmodule

// File: rtl/elastic_buf_chk.sv
module elastic_buf_chk #(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic wr_clk,
  input  logic wr_en,
  input  logic wr_data,
  input  logic rd_clk,
  input  logic rst_n,
  output logic rd_data,
  output logic card_err_n,
  output logic wr_msb,
  output logic rd_msb
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0]  ring_q;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;
  logic [ADDR_W-1:0] samp_addr;
  logic              samp_bit;
  logic              req_tgl;
  logic              req_sync;
  logic              ack_tgl;
  logic              ack_sync;
  logic              pending;
  logic              hit;
  logic              cmp_fire;
  logic              err_q;

  ebc_wr_side #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ack_sync(ack_sync), .ring_q(ring_q), .wr_ptr(wr_ptr),
    .samp_addr(samp_addr), .samp_bit(samp_bit), .req_tgl(req_tgl),
    .pending(pending)
  );

  ebc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(rd_clk), .rst_n(rst_n), .d(req_tgl), .q(req_sync)
  );

  ebc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(wr_clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_sync)
  );

  ebc_rd_side #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .ring_q(ring_q),
    .rd_ptr(rd_ptr), .rd_q(rd_data)
  );

  ebc_rd_check #(.ADDR_W(ADDR_W)) u_chk (
    .rd_clk(rd_clk), .rst_n(rst_n), .req_sync(req_sync), .rd_ptr(rd_ptr),
    .rd_q(rd_data), .samp_addr(samp_addr), .samp_bit(samp_bit),
    .ack_tgl(ack_tgl), .hit(hit), .cmp_fire(cmp_fire), .err_q(err_q)
  );

  assign card_err_n = ~err_q;
  assign wr_msb     = wr_ptr[ADDR_W-1];
  assign rd_msb     = rd_ptr[ADDR_W-1];
endmodule

// File: rtl/elastic_buf_chk_sva.sv
module elastic_buf_chk_sva #(
  parameter int ADDR_W = 4
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W-1:0] rd_ptr,
  input logic [ADDR_W-1:0] samp_addr,
  input logic              samp_bit,
  input logic              pending,
  input logic              hit,
  input logic              cmp_fire,
  input logic              rd_data,
  input logic              card_err_n
);
  AST_WR_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_en |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1))); // R2
  AST_WR_IDLE: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_ptr)); // R2
  AST_RD_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    1'b1 |=> (rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1))); // R3
  AST_SAMPLE_HOLD: assert property (@(posedge wr_clk) disable iff (!rst_n)
    pending |=> ($stable(samp_addr) && $stable(samp_bit))); // R5
  AST_CMP_AFTER_HIT: assert property (@(posedge rd_clk) disable iff (!rst_n)
    hit |=> cmp_fire); // R6
  AST_ERR_SET: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (cmp_fire && (rd_data != samp_bit)) |=> !card_err_n); // R7
  AST_ERR_CLEAR: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (cmp_fire && (rd_data == samp_bit)) |=> card_err_n); // R8
  AST_ERR_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !cmp_fire |=> $stable(card_err_n)); // R8
endmodule

bind elastic_buf_chk elastic_buf_chk_sva #(.ADDR_W(ADDR_W)) u_sva (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .samp_addr(samp_addr),
  .samp_bit(samp_bit), .pending(pending), .hit(hit), .cmp_fire(cmp_fire),
  .rd_data(rd_data), .card_err_n(card_err_n)
);

// File: tb/elastic_buf_chk_tb.sv
module elastic_buf_chk_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RD_DELAY   = 3;
  localparam int DEPTH      = 16;
  localparam int NVEC       = 6;
  // pattern (16 bits, MSB written first) and expected card_err_n after it
  localparam logic [16:0] VEC [NVEC] = '{
    {16'hA5C3, 1'b1}, {16'h0000, 1'b1}, {16'hFFFF, 1'b1},
    {16'h5555, 1'b1}, {16'h8001, 1'b1}, {16'h3C96, 1'b1}
  };

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rd_run = 1'b0;
  logic rst_n  = 1'b0;
  logic wr_en  = 1'b0;
  logic wr_data = 1'b0;
  logic rd_data, card_err_n, wr_msb, rd_msb;

  int n_checks = 0;
  int n_fail   = 0;

  logic [DEPTH-1:0] m_ring;
  int               m_wp;
  int               m_rp;
  logic             exp_rd;

  elastic_buf_chk u_dut (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .rd_clk(rd_clk),
    .rst_n(rst_n), .rd_data(rd_data), .card_err_n(card_err_n),
    .wr_msb(wr_msb), .rd_msb(rd_msb)
  );

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;

  // Read clock: same rate, delayed phase, can be stopped
  always @(posedge wr_clk) begin
    if (rd_run) begin
      #RD_DELAY rd_clk = 1'b1;
      #(CLK_PERIOD/2) rd_clk = 1'b0;
    end
  end

  task automatic chk(input string req, input logic act, input logic expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  // Reference ring, write side
  always @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ring <= '0;
      m_wp   <= DEPTH / 2;
    end else if (wr_en) begin
      m_ring[m_wp] <= wr_data;
      m_wp         <= (m_wp + 1) % DEPTH;
    end
  end

  // Reference ring, read side: every read returns the stored bit (R3)
  always @(negedge rst_n) m_rp = 0;
  always @(posedge rd_clk) begin
    if (rst_n) begin
      exp_rd = m_ring[m_rp];
      m_rp   = (m_rp + 1) % DEPTH;
      #1 chk("R3 rd_data", rd_data, exp_rd);
    end
  end

  task automatic put_bit(input logic d);
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = d;
  endtask

  task automatic stop_writes();
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic read_wait(input int n);
    repeat (n) @(posedge rd_clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic held_msb;
    repeat (3) @(negedge wr_clk);
    chk("R1 wr_msb in reset", wr_msb, 1'b1);
    chk("R1 rd_msb in reset", rd_msb, 1'b0);
    chk("R1 card_err_n in reset", card_err_n, 1'b1);
    rst_n = 1'b1;
    @(negedge wr_clk);
    chk("R1 card_err_n after reset", card_err_n, 1'b1);
    chk("R1 wr_msb after reset", wr_msb, 1'b1);

    // Table walk: streaming at equal rates from the reset offset
    rd_run = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      for (int b = 0; b < 16; b++) put_bit(VEC[i][16-b]);
      @(posedge rd_clk);
      #1;
      chk("R4 msb relation", rd_msb, ~wr_msb);
      chk("R9 no false error", card_err_n, VEC[i][0]);
    end

    // Idle writer: counter must hold, no error
    stop_writes();
    held_msb = wr_msb;
    read_wait(20);
    chk("R2 wr counter holds while gated", wr_msb, held_msb);
    chk("R9 idle no error", card_err_n, 1'b1);

    // Overwrite fault: reader stopped, sampled location rewritten
    @(negedge wr_clk);
    rd_run = 1'b0;
    for (int k = 0; k < DEPTH; k++) put_bit(1'b1);
    for (int k = 0; k < DEPTH; k++) put_bit(1'b0);
    @(negedge wr_clk);
    wr_en  = 1'b0;
    rd_run = 1'b1;
    read_wait(24);
    chk("R7 R5 R6 overwrite detected", card_err_n, 1'b0);
    read_wait(5);
    chk("R8 error held", card_err_n, 1'b0);

    // Recovery: matching comparison clears the flag
    for (int k = 0; k < 40; k++) put_bit(1'b0);
    stop_writes();
    read_wait(20);
    chk("R8 R6 error cleared by match", card_err_n, 1'b1);

    // Reset again mid-run
    @(negedge wr_clk);
    rd_run = 1'b0;
    rst_n  = 1'b0;
    #1;
    chk("R1 wr_msb re-reset", wr_msb, 1'b1);
    chk("R1 rd_msb re-reset", rd_msb, 1'b0);
    chk("R1 card_err_n re-reset", card_err_n, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule